// File: doc/BRIEF.md
# PCI Configuration Access Router

This block sits between the processor's I/O port path and the PCI configuration space of a chip. Software writes a full doubleword into an address register that lives at I/O port 0CF8h, naming a bus, a device, a function and a doubleword register. It then reads or writes the data window at I/O port 0CFCh. When the enable bit of the address register is set, the router turns that data-window access into a configuration read or write cycle aimed at the named register. The byte enables of the I/O access select which of the four bytes take part.

Each configuration cycle goes to exactly one of three request ports:

- **Internal port.** Serves the integrated functions that sit at devices 0 and 1 on bus 0.
- **Graphics port.** Serves the bus range behind the graphics bridge, from its secondary bus to its subordinate bus. The bridge supplies both bus numbers as inputs.
- **Hub port.** Serves every other bus and the remaining bus-0 devices.

Any other I/O access goes out unchanged on a plain I/O port. This includes a data-window access with the enable bit clear. Only one access is in flight at a time. The host holds its request until the block returns a one-cycle acknowledge.

Top module: `cfgr_router`

## Requirements
- R1: A write to the address register with all four byte enables set (4'b1111) loads it. A read of the address register returns its value with bits [30:24] and [1:0] reading 0. The enable bit is bit 31. The bus field is [23:16], the device field [15:11], the function field [10:8] and the doubleword register field [7:2].
- R2: A write to the address register with any other byte-enable pattern leaves the register unchanged. No access at the address register starts a configuration or plain I/O request.
- R3: A data-window access made while the enable bit is 0 is forwarded on the plain I/O port with the same address, byte enables, direction and write data. It produces no configuration request.
- R4: A data-window access made while the enable bit is 1 produces one configuration request. The request carries the bus, device, function and register fields of the address register, together with the direction, byte enables and write data of the I/O access.
- R5: A configuration request for bus 0, device 0 or 1, goes to the internal port (cfg_req bit 0).
- R6: A configuration request for bus 0 and any device from 2 upward goes to the hub port (cfg_req bit 1).
- R7: A configuration request for a nonzero bus between the graphics secondary and subordinate bus numbers, inclusive, goes to the graphics port (cfg_req bit 2). Any other nonzero bus goes to the hub port, and so does every nonzero bus when the secondary number exceeds the subordinate number.
- R8: An I/O access to any doubleword other than 0CF8h and 0CFCh is forwarded on the plain I/O port, whatever the enable bit holds.
- R9: The router has at most one request active, and it holds that request and its fields until the matching ack. io_ack is a one-cycle pulse. It arrives the cycle after the downstream ack, or the cycle after acceptance for an address-register access.
- R10: On configuration reads, data bytes whose byte enable is clear return 0. Plain I/O read data is returned unchanged.
- R11: After reset, no request is active, io_ack is low and the address register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host I/O request, held until io_ack |
| io_we | input | 1 | Host access is a write |
| io_addr | input | 16 | Host I/O byte address (bits [1:0] not used for decode) |
| io_be | input | 4 | Host byte enables |
| io_wdata | input | 32 | Host write data |
| io_ack | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_ack |
| gfx_sec_bus | input | 8 | Graphics bridge secondary bus number |
| gfx_sub_bus | input | 8 | Graphics bridge subordinate bus number |
| cfg_req | output | 3 | One-hot configuration request: bit 0 internal, bit 1 hub, bit 2 graphics |
| cfg_we | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 6 | Target doubleword register index |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 3 | Per-port completion, one cycle |
| cfg_rdata | input | 96 | Per-port read data, port n in bits [32n+31:32n] |
| pio_req | output | 1 | Plain I/O request, held until pio_ack |
| pio_we | output | 1 | Plain I/O write |
| pio_addr | output | 16 | Plain I/O address |
| pio_be | output | 4 | Plain I/O byte enables |
| pio_wdata | output | 32 | Plain I/O write data |
| pio_ack | input | 1 | Plain I/O completion, one cycle |
| pio_rdata | input | 32 | Plain I/O read data |

## Verification
Routing is swept across the grid formed by bus numbers 0, 1, 2, 3, 5, 6, 7 and 255, devices 0, 1, 2 and 31, and two functions. This grid is run under three graphics windows: a normal window, an empty window with the secondary number above the subordinate, and a window reaching bus 255. It separates the internal, hub and graphics decisions at every window edge. Each target model answers with data built from its own port number and the fields it received, and with its own latency. A wrong port selection, a wrong field or a wrong acknowledge timing therefore shows up in the returned data or the cycle count. Byte-enable patterns are varied per access, so both the byte-lane masking of configuration reads and the forwarding of the enables are exercised. The full set of partial patterns written to the address register checks that those writes are ignored.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
   localparam int NTGT    = 3;
   localparam int TGT_INT = 0;
   localparam int TGT_HUB = 1;
   localparam int TGT_GFX = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CFG  = 2'd1,
      ST_PIO  = 2'd2,
      ST_RESP = 2'd3
   } cfgr_state_e;
endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg #(
   parameter int             DW   = 32,
   parameter logic [DW-1:0]  KEEP = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= wdata & KEEP;
   end
endmodule

// File: rtl/cfgr_route.sv
module cfgr_route
   import cfgr_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int DEV_W       = 5,
   parameter int NUM_INT_DEV = 2
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic [BUS_W-1:0] sec_bus,
   input  logic [BUS_W-1:0] sub_bus,
   output logic [NTGT-1:0]  tgt
);
   if (NUM_INT_DEV > (1 << DEV_W)) begin : g_bad_int
      $error("cfgr_route: NUM_INT_DEV exceeds device field range");
   end

   logic in_window;
   assign in_window = (bus >= sec_bus) && (bus <= sub_bus);

   always_comb begin
      tgt = '0;
      if (bus == '0) begin
         if (dev < DEV_W'(NUM_INT_DEV))
            tgt[TGT_INT] = 1'b1;
         else
            tgt[TGT_HUB] = 1'b1;
      end else if (in_window) begin
         tgt[TGT_GFX] = 1'b1;
      end else begin
         tgt[TGT_HUB] = 1'b1;
      end
   end
endmodule

// File: rtl/cfgr_seq.sv
module cfgr_seq
   import cfgr_pkg::*;
#(
   parameter int IO_AW   = 16,
   parameter int DW      = 32,
   parameter bit MASK_RD = 1'b1,
   localparam int BEW    = DW / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_req,
   input  logic               io_we,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic [BEW-1:0]     io_be,
   input  logic [DW-1:0]      io_wdata,
   input  logic               hit_areg,
   input  logic               cfg_go,
   input  logic [NTGT-1:0]    route,
   input  logic [DW-1:0]      areg_q,
   input  logic [NTGT-1:0]    cfg_ack,
   input  logic [NTGT*DW-1:0] cfg_rdata,
   input  logic               pio_ack,
   input  logic [DW-1:0]      pio_rdata,
   output logic [NTGT-1:0]    cfg_req,
   output logic               pio_req,
   output logic               lat_we,
   output logic [IO_AW-1:0]   lat_addr,
   output logic [BEW-1:0]     lat_be,
   output logic [DW-1:0]      lat_wdata,
   output logic               io_ack,
   output logic [DW-1:0]      io_rdata,
   output logic               areg_load
);
   cfgr_state_e         state;
   logic [NTGT-1:0]     tgt_q;
   logic [DW-1:0]       rdata_q;
   logic [DW-1:0]       sel;
   logic [DW-1:0]       sel_m;
   logic                tgt_done;

   always_comb begin
      sel = '0;
      for (int t = 0; t < NTGT; t++) begin
         if (tgt_q[t])
            sel = sel | cfg_rdata[t*DW +: DW];
      end
   end

   if (MASK_RD) begin : g_mask
      for (genvar b = 0; b < BEW; b++) begin : g_lane
         assign sel_m[8*b +: 8] = lat_be[b] ? sel[8*b +: 8] : 8'h00;
      end
   end else begin : g_nomask
      assign sel_m = sel;
   end

   assign tgt_done  = |(tgt_q & cfg_ack);
   assign areg_load = (state == ST_IDLE) && io_req && hit_areg && io_we && (&io_be);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tgt_q     <= '0;
         rdata_q   <= '0;
         lat_we    <= 1'b0;
         lat_addr  <= '0;
         lat_be    <= '0;
         lat_wdata <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (io_req) begin
                  lat_we    <= io_we;
                  lat_addr  <= io_addr;
                  lat_be    <= io_be;
                  lat_wdata <= io_wdata;
                  if (hit_areg) begin
                     rdata_q <= areg_q;
                     state   <= ST_RESP;
                  end else if (cfg_go) begin
                     tgt_q <= route;
                     state <= ST_CFG;
                  end else begin
                     state <= ST_PIO;
                  end
               end
            end
            ST_CFG: begin
               if (tgt_done) begin
                  rdata_q <= sel_m;
                  state   <= ST_RESP;
               end
            end
            ST_PIO: begin
               if (pio_ack) begin
                  rdata_q <= pio_rdata;
                  state   <= ST_RESP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cfg_req  = (state == ST_CFG) ? tgt_q : '0;
   assign pio_req  = (state == ST_PIO);
   assign io_ack   = (state == ST_RESP);
   assign io_rdata = rdata_q;
endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
   import cfgr_pkg::*;
#(
   parameter int               IO_AW       = 16,
   parameter int               DW          = 32,
   parameter int               BUS_W       = 8,
   parameter int               DEV_W       = 5,
   parameter int               FN_W        = 3,
   parameter int               REG_W       = 6,
   parameter int               EN_BIT      = 31,
   parameter int               NUM_INT_DEV = 2,
   parameter bit               MASK_RD     = 1'b1,
   parameter logic [IO_AW-1:0] AREG_PORT   = 'h0CF8,
   parameter logic [IO_AW-1:0] DWIN_PORT   = 'h0CFC,
   localparam int              BEW         = DW / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_req,
   input  logic               io_we,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic [BEW-1:0]     io_be,
   input  logic [DW-1:0]      io_wdata,
   output logic               io_ack,
   output logic [DW-1:0]      io_rdata,
   input  logic [BUS_W-1:0]   gfx_sec_bus,
   input  logic [BUS_W-1:0]   gfx_sub_bus,
   output logic [NTGT-1:0]    cfg_req,
   output logic               cfg_we,
   output logic [BUS_W-1:0]   cfg_bus,
   output logic [DEV_W-1:0]   cfg_dev,
   output logic [FN_W-1:0]    cfg_fn,
   output logic [REG_W-1:0]   cfg_reg,
   output logic [BEW-1:0]     cfg_be,
   output logic [DW-1:0]      cfg_wdata,
   input  logic [NTGT-1:0]    cfg_ack,
   input  logic [NTGT*DW-1:0] cfg_rdata,
   output logic               pio_req,
   output logic               pio_we,
   output logic [IO_AW-1:0]   pio_addr,
   output logic [BEW-1:0]     pio_be,
   output logic [DW-1:0]      pio_wdata,
   input  logic               pio_ack,
   input  logic [DW-1:0]      pio_rdata
);
   localparam int REG_LSB = 2;
   localparam int FN_LSB  = REG_LSB + REG_W;
   localparam int DEV_LSB = FN_LSB + FN_W;
   localparam int BUS_LSB = DEV_LSB + DEV_W;
   localparam int FLD_TOP = BUS_LSB + BUS_W;
   localparam logic [DW-1:0] FLD_MASK =
      ((DW'(1) << FLD_TOP) - DW'(1)) & ~((DW'(1) << REG_LSB) - DW'(1));
   localparam logic [DW-1:0] KEEP = (DW'(1) << EN_BIT) | FLD_MASK;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("cfgr_router: DW must be a whole number of bytes");
   end
   if (EN_BIT >= DW || FLD_TOP > EN_BIT) begin : g_bad_fields
      $error("cfgr_router: address fields overlap the enable bit");
   end
   if (AREG_PORT[1:0] != 2'b00 || DWIN_PORT[1:0] != 2'b00) begin : g_bad_align
      $error("cfgr_router: port addresses must be doubleword aligned");
   end
   if (AREG_PORT[IO_AW-1:2] == DWIN_PORT[IO_AW-1:2]) begin : g_bad_ports
      $error("cfgr_router: address and data ports must differ");
   end

   logic                hit_areg;
   logic                hit_dwin;
   logic                cfg_go;
   logic                areg_load;
   logic [DW-1:0]       areg_q;
   logic [NTGT-1:0]     route;
   logic                lat_we;
   logic [IO_AW-1:0]    lat_addr;
   logic [BEW-1:0]      lat_be;
   logic [DW-1:0]       lat_wdata;

   assign hit_areg = (io_addr[IO_AW-1:2] == AREG_PORT[IO_AW-1:2]);
   assign hit_dwin = (io_addr[IO_AW-1:2] == DWIN_PORT[IO_AW-1:2]);
   assign cfg_go   = hit_dwin && areg_q[EN_BIT];

   cfgr_addr_reg #(
      .DW   (DW),
      .KEEP (KEEP)
   ) u_areg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (areg_load),
      .wdata (io_wdata),
      .q     (areg_q)
   );

   assign cfg_bus = areg_q[BUS_LSB +: BUS_W];
   assign cfg_dev = areg_q[DEV_LSB +: DEV_W];
   assign cfg_fn  = areg_q[FN_LSB  +: FN_W];
   assign cfg_reg = areg_q[REG_LSB +: REG_W];

   cfgr_route #(
      .BUS_W       (BUS_W),
      .DEV_W       (DEV_W),
      .NUM_INT_DEV (NUM_INT_DEV)
   ) u_route (
      .bus     (cfg_bus),
      .dev     (cfg_dev),
      .sec_bus (gfx_sec_bus),
      .sub_bus (gfx_sub_bus),
      .tgt     (route)
   );

   cfgr_seq #(
      .IO_AW   (IO_AW),
      .DW      (DW),
      .MASK_RD (MASK_RD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_req    (io_req),
      .io_we     (io_we),
      .io_addr   (io_addr),
      .io_be     (io_be),
      .io_wdata  (io_wdata),
      .hit_areg  (hit_areg),
      .cfg_go    (cfg_go),
      .route     (route),
      .areg_q    (areg_q),
      .cfg_ack   (cfg_ack),
      .cfg_rdata (cfg_rdata),
      .pio_ack   (pio_ack),
      .pio_rdata (pio_rdata),
      .cfg_req   (cfg_req),
      .pio_req   (pio_req),
      .lat_we    (lat_we),
      .lat_addr  (lat_addr),
      .lat_be    (lat_be),
      .lat_wdata (lat_wdata),
      .io_ack    (io_ack),
      .io_rdata  (io_rdata),
      .areg_load (areg_load)
   );

   assign cfg_we    = lat_we;
   assign cfg_be    = lat_be;
   assign cfg_wdata = lat_wdata;
   assign pio_we    = lat_we;
   assign pio_addr  = lat_addr;
   assign pio_be    = lat_be;
   assign pio_wdata = lat_wdata;
endmodule

// File: rtl/cfgr_router_chk.sv
module cfgr_router_chk
   import cfgr_pkg::*;
#(
   parameter int               IO_AW       = 16,
   parameter int               DW          = 32,
   parameter int               BUS_W       = 8,
   parameter int               DEV_W       = 5,
   parameter int               FN_W        = 3,
   parameter int               REG_W       = 6,
   parameter int               NUM_INT_DEV = 2,
   parameter logic [IO_AW-1:0] AREG_PORT   = 'h0CF8,
   localparam int              BEW         = DW / 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             io_ack,
   input logic [NTGT-1:0]  cfg_req,
   input logic [NTGT-1:0]  cfg_ack,
   input logic             cfg_we,
   input logic [BUS_W-1:0] cfg_bus,
   input logic [DEV_W-1:0] cfg_dev,
   input logic [FN_W-1:0]  cfg_fn,
   input logic [REG_W-1:0] cfg_reg,
   input logic [BEW-1:0]   cfg_be,
   input logic [DW-1:0]    cfg_wdata,
   input logic             pio_req,
   input logic [IO_AW-1:0] pio_addr,
   input logic [BUS_W-1:0] gfx_sec_bus,
   input logic [BUS_W-1:0] gfx_sub_bus
);
   logic waiting;
   assign waiting = (|cfg_req) && !(|(cfg_req & cfg_ack));

   // R9
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_req, pio_req, io_ack}));

   // R9
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |=> $stable(cfg_req));

   // R4
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |=> ($stable(cfg_bus) && $stable(cfg_dev) && $stable(cfg_fn) &&
                   $stable(cfg_reg) && $stable(cfg_be) && $stable(cfg_we) &&
                   $stable(cfg_wdata)));

   // R9
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_ack |=> !io_ack);

   // R5
   int_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req[TGT_INT]) |-> (cfg_bus == '0 && cfg_dev < DEV_W'(NUM_INT_DEV)));

   // R7
   gfx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req[TGT_GFX]) |-> (cfg_bus != '0 && cfg_bus >= $past(gfx_sec_bus) &&
                                    cfg_bus <= $past(gfx_sub_bus)));

   // R6
   hub_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req[TGT_HUB]) |->
         (!(cfg_bus == '0 && cfg_dev < DEV_W'(NUM_INT_DEV)) &&
          !(cfg_bus != '0 && cfg_bus >= $past(gfx_sec_bus) &&
            cfg_bus <= $past(gfx_sub_bus))));

   // R2
   no_areg_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pio_req |-> (pio_addr[IO_AW-1:2] != AREG_PORT[IO_AW-1:2]));
endmodule

bind cfgr_router cfgr_router_chk #(
   .IO_AW       (IO_AW),
   .DW          (DW),
   .BUS_W       (BUS_W),
   .DEV_W       (DEV_W),
   .FN_W        (FN_W),
   .REG_W       (REG_W),
   .NUM_INT_DEV (NUM_INT_DEV),
   .AREG_PORT   (AREG_PORT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_ack      (io_ack),
   .cfg_req     (cfg_req),
   .cfg_ack     (cfg_ack),
   .cfg_we      (cfg_we),
   .cfg_bus     (cfg_bus),
   .cfg_dev     (cfg_dev),
   .cfg_fn      (cfg_fn),
   .cfg_reg     (cfg_reg),
   .cfg_be      (cfg_be),
   .cfg_wdata   (cfg_wdata),
   .pio_req     (pio_req),
   .pio_addr    (pio_addr),
   .gfx_sec_bus (gfx_sec_bus),
   .gfx_sub_bus (gfx_sub_bus)
);

// File: tb/cfgr_router_tb.sv
module cfgr_router_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0;
   logic        io_we = 1'b0;
   logic [15:0] io_addr = '0;
   logic [3:0]  io_be = '0;
   logic [31:0] io_wdata = '0;
   logic        io_ack;
   logic [31:0] io_rdata;
   logic [7:0]  gfx_sec_bus = 8'd2;
   logic [7:0]  gfx_sub_bus = 8'd5;
   logic [2:0]  cfg_req;
   logic        cfg_we;
   logic [7:0]  cfg_bus;
   logic [4:0]  cfg_dev;
   logic [2:0]  cfg_fn;
   logic [5:0]  cfg_reg;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic [2:0]  cfg_ack = '0;
   logic [95:0] cfg_rdata = '0;
   logic        pio_req;
   logic        pio_we;
   logic [15:0] pio_addr;
   logic [3:0]  pio_be;
   logic [31:0] pio_wdata;
   logic        pio_ack = 1'b0;
   logic [31:0] pio_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   int n_cfg_seen = 0;
   int n_pio_seen = 0;
   logic [2:0]  s_tgt;
   logic [23:0] s_fld;
   logic [3:0]  s_be;
   logic        s_we;
   logic [31:0] s_wdata;
   logic [15:0] s_paddr;

   always #(CLK_P/2) clk = ~clk;

   cfgr_router u_dut (
      .clk(clk), .rst_n(rst_n),
      .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_be(io_be),
      .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
      .gfx_sec_bus(gfx_sec_bus), .gfx_sub_bus(gfx_sub_bus),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
      .pio_req(pio_req), .pio_we(pio_we), .pio_addr(pio_addr), .pio_be(pio_be),
      .pio_wdata(pio_wdata), .pio_ack(pio_ack), .pio_rdata(pio_rdata)
   );

   function automatic logic [31:0] tgt_data(input int t, input logic [7:0] bus,
                                            input logic [4:0] dev, input logic [2:0] fn,
                                            input logic [5:0] rg);
      return {8'h10 + 8'(t), bus, 3'b000, dev, fn, rg[4:0]};
   endfunction

   function automatic logic [2:0] exp_tgt(input logic [7:0] bus, input logic [4:0] dev,
                                          input logic [7:0] sec, input logic [7:0] sub);
      if (bus == 8'd0) return (dev < 5'd2) ? 3'b001 : 3'b010;
      if (bus >= sec && bus <= sub) return 3'b100;
      return 3'b010;
   endfunction

   function automatic logic [31:0] mask_be(input logic [31:0] d, input logic [3:0] be);
      return d & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   // target models: internal answers after 1 cycle, hub 2, graphics 3; plain I/O 1
   initial begin
      forever begin
         @(negedge clk);
         cfg_ack = '0;
         pio_ack = 1'b0;
         if (rst_n && cfg_req != '0) begin
            n_cfg_seen++;
            s_tgt   = cfg_req;
            s_fld   = {cfg_bus, cfg_dev, cfg_fn, cfg_reg, 2'b00};
            s_be    = cfg_be;
            s_we    = cfg_we;
            s_wdata = cfg_wdata;
            repeat ((cfg_req == 3'b001) ? 0 : (cfg_req == 3'b010) ? 1 : 2) @(negedge clk);
            for (int t = 0; t < 3; t++)
               cfg_rdata[t*32 +: 32] = tgt_data(t, cfg_bus, cfg_dev, cfg_fn, cfg_reg);
            cfg_ack = cfg_req;
         end else if (rst_n && pio_req) begin
            n_pio_seen++;
            s_paddr   = pio_addr;
            s_be      = pio_be;
            s_we      = pio_we;
            s_wdata   = pio_wdata;
            pio_rdata = {16'hA5C3, pio_addr};
            pio_ack   = 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic we, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd, output int ncyc);
      n_cfg_seen = 0;
      n_pio_seen = 0;
      @(negedge clk);
      io_req = 1'b1; io_we = we; io_addr = a; io_be = be; io_wdata = wd;
      ncyc = 0;
      do begin
         @(negedge clk);
         ncyc++;
      end while (!io_ack);
      rd = io_rdata;
      io_req = 1'b0;
   endtask

   task automatic set_areg(input logic [31:0] v);
      logic [31:0] rd;
      int nc;
      xfer(1'b1, 16'h0CF8, 4'hF, v, rd, nc);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int nc;
      logic [31:0] base;
      logic [7:0]  buses [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd6, 8'd7, 8'd255};
      logic [4:0]  devs  [4] = '{5'd0, 5'd1, 5'd2, 5'd31};
      logic [7:0]  secs  [3] = '{8'd2, 8'd6, 8'd1};
      logic [7:0]  subs  [3] = '{8'd5, 8'd3, 8'd255};
      logic [15:0] others[3] = '{16'h0CF4, 16'h0080, 16'h0D00};

      repeat (4) @(negedge clk);
      chk("R11 io_ack in reset", 32'(io_ack), 32'd0);
      chk("R11 cfg_req in reset", 32'(cfg_req), 32'd0);
      chk("R11 pio_req in reset", 32'(pio_req), 32'd0);
      rst_n = 1'b1;
      xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, nc);
      chk("R11 address register after reset", rd, 32'd0);

      // R1: load and reserved bits
      foreach (others[i]) begin end
      begin
         logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'h80A5_F0FF};
         foreach (pats[i]) begin
            set_areg(pats[i]);
            xfer(1'b0, 16'h0CFB, 4'h1, '0, rd, nc);
            chk("R1 address register readback", rd, pats[i] & 32'h80FF_FFFC);
            chk("R9 address register ack latency", 32'(nc), 32'd1);
            chk("R2 no downstream on address register", 32'(n_cfg_seen + n_pio_seen), 32'd0);
         end
      end

      // R2: partial writes ignored
      base = 32'h8011_2230;
      set_areg(base);
      for (int be = 0; be < 15; be++) begin
         xfer(1'b1, 16'h0CF8, 4'(be), 32'hFFFF_FFFF, rd, nc);
         chk("R2 no downstream on partial write", 32'(n_cfg_seen + n_pio_seen), 32'd0);
         xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, nc);
         chk("R2 partial write ignored", rd, base);
      end

      // R3: enable clear passes through as plain I/O
      set_areg(32'h0001_0800);
      for (int be = 1; be < 16; be++) begin
         xfer(1'b0, 16'h0CFC, 4'(be), '0, rd, nc);
         chk("R3 no config cycle when disabled", 32'(n_cfg_seen), 32'd0);
         chk("R3 plain I/O request issued", 32'(n_pio_seen), 32'd1);
         chk("R3 plain I/O byte enables", 32'(s_be), 32'(be));
         chk("R10 plain I/O read data unmasked", rd, 32'hA5C3_0CFC);
         xfer(1'b1, 16'h0CFE, 4'(be), 32'hC0DE_0000 + 32'(be), rd, nc);
         chk("R3 plain I/O write fields", {s_we, 15'd0, s_paddr}, {1'b1, 15'd0, 16'h0CFE});
         chk("R3 plain I/O write data", s_wdata, 32'hC0DE_0000 + 32'(be));
      end

      // R4..R7, R9, R10: routing sweep under three graphics windows
      for (int w = 0; w < 3; w++) begin
         gfx_sec_bus = secs[w];
         gfx_sub_bus = subs[w];
         foreach (buses[bi]) foreach (devs[di]) for (int fn = 0; fn < 8; fn += 5) begin
            logic [7:0]  bus;
            logic [4:0]  dev;
            logic [5:0]  rg;
            logic [3:0]  be;
            logic [31:0] av;
            logic [2:0]  et;
            int          ti;
            string       tag;
            bus = buses[bi];
            dev = devs[di];
            rg  = 6'((int'(bus) + int'(dev) + fn) % 64);
            be  = 4'((int'(bus) + int'(dev) + fn + w) % 15 + 1);
            av  = {1'b1, 7'd0, bus, dev, 3'(fn), rg, 2'b00};
            et  = exp_tgt(bus, dev, gfx_sec_bus, gfx_sub_bus);
            ti  = (et == 3'b001) ? 0 : (et == 3'b010) ? 1 : 2;
            tag = (bus == 8'd0) ? ((dev < 5'd2) ? "R5 route" : "R6 route") : "R7 route";
            set_areg(av);
            xfer(1'b0, 16'h0CFC, be, '0, rd, nc);
            chk("R4 one config cycle", 32'(n_cfg_seen + n_pio_seen), 32'd1);
            chk(tag, 32'(s_tgt), 32'(et));
            chk("R4 config fields", 32'(s_fld), av[23:0] & 32'h00FF_FFFC);
            chk("R4 config byte enables", 32'(s_be), 32'(be));
            chk("R10 config read data", rd, mask_be(tgt_data(ti, bus, dev, 3'(fn), rg), be));
            chk("R9 ack latency", 32'(nc), 32'(ti + 2));
            xfer(1'b1, 16'h0CFC, be, av ^ 32'h5A5A_5A5A, rd, nc);
            chk("R4 config write fields", {s_we, 27'd0, s_be}, {1'b1, 27'd0, be});
            chk("R4 config write data", s_wdata, av ^ 32'h5A5A_5A5A);
         end
      end

      // R8: other I/O addresses always plain I/O
      gfx_sec_bus = 8'd2;
      gfx_sub_bus = 8'd5;
      set_areg(32'h8000_0000);
      foreach (others[i]) begin
         xfer(1'b0, others[i], 4'h3, '0, rd, nc);
         chk("R8 no config cycle", 32'(n_cfg_seen), 32'd0);
         chk("R8 plain I/O address", 32'(s_paddr), 32'(others[i]));
         chk("R8 plain I/O read data", rd, {16'hA5C3, others[i]});
         chk("R9 plain I/O ack latency", 32'(nc), 32'd2);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule